// File: doc/BRIEF.md
# Calendar Time Update and Alarm Engine

This block keeps the running time of day and the calendar date as binary counts: seconds, minutes, hours, day of week, day of month, month and year. Each accepted one-second enable advances the count by one second. The advance handles minute, hour and day carries, month lengths, leap years and the year rollover. The block then raises an update-in-progress flag. It waits a fixed number of 32 kHz ticks, and then does three things in one cycle: it refreshes the seven visible time bytes, evaluates a three-field alarm, and drops the flag.

The visible time bytes are kept in either BCD or plain binary, and the hour byte in either 24-hour or 12-hour form. A hold control freezes the visible bytes while software rewrites them. The running count keeps advancing during the hold. When the hold is released, the count is reloaded from the seven bytes. A byte written while hold is low is decoded straight into the running count. The alarm and update-ended outputs are one-cycle pulses; the flag register that collects them is outside this block.

Top module: `tod_update_engine`

## Requirements
- R1: A one-cycle `sec_pulse` is accepted only when `osc_sel` equals 3'b010. With any other value, nothing happens: no count change, no `uip`, no byte refresh and no pulses.
- R2: The cycle after an accepted pulse, `uip` is 1 if `hold` is low. On the edge of the 8th `tick_32k` after the pulse, three things happen together: the bytes refresh, the pulses fire and `uip` returns to 0. A `sec_pulse` that arrives while a refresh is pending is ignored.
- R3: Seconds and minutes wrap 59→0 and hours wrap 23→0, each carrying into the next field. Day of week wraps 6→0. Day of month wraps to 1 after the month's last day and advances the month. December advances the year. February has 29 days when the full year (2000 + count) is divisible by 4 and either not by 100 or by 400.
- R4: With `bin_mode`=1, all time and alarm bytes are plain binary. With `bin_mode`=0 they are two-digit BCD, tens in bits 7:4.
- R5: With `h24_mode`=1 the hour byte holds 0–23. With `h24_mode`=0 it holds hour mod 12, with bit 7 set for hours 12–23.
- R6: The month byte holds 1–12. The year byte holds the year count mod 100.
- R7: Each alarm byte matches when its bits 7:6 are both 1, or when its decoded value equals the current second, minute or hour (the hour taken as 0–23). On a refresh edge, a full match with `alarm_en`=1 gives a one-cycle `alarm_pulse`.
- R8: On every refresh edge with `upd_en`=1, `upd_pulse` is high for one cycle.
- R9: While `hold`=1, `uip` is 0 from the next cycle on and the refresh does not change the time bytes. The count still advances, and the alarm compares against the advanced count.
- R10: `wr_sel` picks the byte to write: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 none. A write always stores the byte. With `hold`=0 it also loads the decoded value into the count. With `hold`=1 it does not. The falling edge of `hold` reloads the count from all seven bytes.
- R11: After reset the time bytes read seconds, minutes, hours and day of week 0, day of month 1, month 1, year 0. `uip` and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_pulse | input | 1 | One-second enable |
| tick_32k | input | 1 | 32 kHz tick enable |
| osc_sel | input | 3 | Divider field; 3'b010 runs the clock |
| hold | input | 1 | Freeze visible bytes for setting |
| bin_mode | input | 1 | 1 binary, 0 BCD |
| h24_mode | input | 1 | 1 24-hour, 0 12-hour |
| alarm_en | input | 1 | Alarm pulse enable |
| upd_en | input | 1 | Update-ended pulse enable |
| wr_en | input | 1 | Time byte write strobe |
| wr_sel | input | 3 | Time byte select |
| wr_data | input | 8 | Write data |
| alarm_sec | input | 8 | Alarm seconds byte |
| alarm_min | input | 8 | Alarm minutes byte |
| alarm_hour | input | 8 | Alarm hours byte |
| t_sec | output | 8 | Seconds byte |
| t_min | output | 8 | Minutes byte |
| t_hour | output | 8 | Hours byte |
| t_wday | output | 8 | Day-of-week byte |
| t_mday | output | 8 | Day-of-month byte |
| t_mon | output | 8 | Month byte |
| t_year | output | 8 | Year byte |
| uip | output | 1 | Update in progress |
| alarm_pulse | output | 1 | Alarm match pulse |
| upd_pulse | output | 1 | Update-ended pulse |

## Verification
Directed dates just before a rollover tell apart the carry chain, the month-length table and the three leap outcomes: the year 2000 is leap, 2100 is not, and a plain multiple of four is leap. Random dates, encoding modes and half-wildcard alarms in BCD and binary, 12-hour and 24-hour forms check that the encode and decode paths agree, and that a wildcard field and an exact field are judged independently. A second pulse under a stopped divider, a pulse injected mid-window and a hold sequence isolate the gating. The hold sequence shows three things: bytes frozen, the count still advancing as seen through the alarm, and the reload from the bytes on release.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam logic [2:0] OSC_RUN = 3'b010;
  localparam int NFIELD  = 7;
  localparam int FS_SEC  = 0;
  localparam int FS_MIN  = 1;
  localparam int FS_HOUR = 2;
  localparam int FS_WDAY = 3;
  localparam int FS_MDAY = 4;
  localparam int FS_MON  = 5;
  localparam int FS_YEAR = 6;

  // Six 8-bit calendar fields below the year, indexed by FS_*.
  typedef logic [NFIELD-2:0][7:0] tod_lo_t;

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b, input logic bin);
    return bin ? b : (8'(b[7:4]) * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [7:0] v, input logic bin);
    logic [7:0] tens, ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return bin ? v : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] decode_field(input logic [2:0] f, input logic [7:0] b,
                                              input logic bin, input logic h24);
    logic [7:0] v;
    case (f)
      3'd2: begin
        v = bcd_to_bin({1'b0, b[6:0]}, bin);
        if (!h24 && b[7]) v = v + 8'd12;
      end
      3'd5:    v = bcd_to_bin(b, bin) - 8'd1;
      default: v = bcd_to_bin(b, bin);
    endcase
    return v;
  endfunction

  function automatic logic [7:0] encode_hour(input logic [7:0] h, input logic bin,
                                             input logic h24);
    if (h24) return bin_to_bcd(h, bin);
    return bin_to_bcd(h % 8'd12, bin) | ((h >= 8'd12) ? 8'h80 : 8'h00);
  endfunction

  function automatic logic leap_year(input logic [15:0] y);
    return (y % 16'd4 == 16'd0) && ((y % 16'd100 != 16'd0) || (y % 16'd400 == 16'd0));
  endfunction

  function automatic logic [7:0] days_in_month(input logic [7:0] mon0, input logic lp);
    case (mon0)
      8'd1:                      return lp ? 8'd29 : 8'd28;
      8'd3, 8'd5, 8'd8, 8'd10:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/tod_count.sv
`timescale 1ns/1ps
module tod_count
  import tod_pkg::*;
#(
  parameter int YEAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [NFIELD-1:0] ld_mask,
  input  tod_lo_t           ld_lo,
  input  logic [YEAR_W-1:0] ld_year,
  output tod_lo_t           cur_lo,
  output logic [YEAR_W-1:0] cur_year
);
  tod_lo_t           nxt_lo;
  logic [YEAR_W-1:0] nxt_year;
  logic [8:0]        inc_sec, inc_min, inc_hour, inc_mday;
  logic [7:0]        inc_wday, inc_mon, dim;

  always_comb begin
    nxt_lo   = cur_lo;
    nxt_year = cur_year;
    inc_sec  = {1'b0, cur_lo[FS_SEC]}  + 9'd1;
    inc_min  = {1'b0, cur_lo[FS_MIN]}  + 9'd1;
    inc_hour = {1'b0, cur_lo[FS_HOUR]} + 9'd1;
    inc_mday = {1'b0, cur_lo[FS_MDAY]} + 9'd1;
    inc_wday = cur_lo[FS_WDAY] + 8'd1;
    inc_mon  = cur_lo[FS_MON]  + 8'd1;
    dim      = days_in_month(cur_lo[FS_MON], leap_year(16'(cur_year)));
    if (step) begin
      if (inc_sec < 9'd60) nxt_lo[FS_SEC] = inc_sec[7:0];
      else begin
        nxt_lo[FS_SEC] = 8'd0;
        if (inc_min < 9'd60) nxt_lo[FS_MIN] = inc_min[7:0];
        else begin
          nxt_lo[FS_MIN] = 8'd0;
          if (inc_hour < 9'd24) nxt_lo[FS_HOUR] = inc_hour[7:0];
          else begin
            nxt_lo[FS_HOUR] = 8'd0;
            nxt_lo[FS_WDAY] = (inc_wday >= 8'd7) ? 8'd0 : inc_wday;
            if (inc_mday > {1'b0, dim}) begin
              nxt_lo[FS_MDAY] = 8'd1;
              if (inc_mon >= 8'd12) begin
                nxt_lo[FS_MON] = 8'd0;
                nxt_year       = cur_year + 1'b1;
              end else begin
                nxt_lo[FS_MON] = inc_mon;
              end
            end else begin
              nxt_lo[FS_MDAY] = inc_mday[7:0];
            end
          end
        end
      end
    end
    for (int i = 0; i < NFIELD-1; i++)
      if (ld_mask[i]) nxt_lo[i] = ld_lo[i];
    if (ld_mask[FS_YEAR]) nxt_year = ld_year;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lo          <= '0;
      cur_lo[FS_MDAY] <= 8'd1;
      cur_year        <= '0;
    end else begin
      cur_lo   <= nxt_lo;
      cur_year <= nxt_year;
    end
  end

  // R1: without an accepted step or a load the count does not move
  assert_count_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && ld_mask == '0) |=> ($stable(cur_lo) && $stable(cur_year)));
  // R3: every step changes the seconds field
  assert_sec_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ld_mask == '0) |=> (cur_lo[FS_SEC] != $past(cur_lo[FS_SEC])));
endmodule

// File: rtl/tod_seq.sv
`timescale 1ns/1ps
module tod_seq
  import tod_pkg::*;
#(
  parameter int TICK_DELAY = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_pulse,
  input  logic       tick,
  input  logic [2:0] osc_sel,
  input  logic       hold,
  output logic       step,
  output logic       finish,
  output logic       uip
);
  localparam int CW = $clog2(TICK_DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_DELAY - 1);

  logic          busy, busy_n, uip_n;
  logic [CW-1:0] cnt, cnt_n;

  assign step   = !busy && sec_pulse && (osc_sel == OSC_RUN);
  assign finish = busy && tick && (cnt == LAST);

  always_comb begin
    busy_n = busy;
    cnt_n  = cnt;
    uip_n  = uip;
    if (step) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      uip_n  = 1'b1;
    end else if (busy && tick) begin
      cnt_n = cnt + 1'b1;
      if (finish) begin
        busy_n = 1'b0;
        uip_n  = 1'b0;
      end
    end
    if (hold) uip_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      uip  <= 1'b0;
    end else begin
      busy <= busy_n;
      cnt  <= cnt_n;
      uip  <= uip_n;
    end
  end

  assert_uip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !uip);
  assert_uip_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(sec_pulse));
  assert_uip_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !uip);
endmodule

// File: rtl/tod_alarm.sv
`timescale 1ns/1ps
module tod_alarm
  import tod_pkg::*;
(
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] a_sec,
  input  logic [7:0] a_min,
  input  logic [7:0] a_hour,
  input  logic       bin,
  output logic       match
);
  logic hit_s, hit_m, hit_h;

  assign hit_s = (&a_sec[7:6])  || (bcd_to_bin(a_sec, bin)  == cur_sec);
  assign hit_m = (&a_min[7:6])  || (bcd_to_bin(a_min, bin)  == cur_min);
  assign hit_h = (&a_hour[7:6]) || (bcd_to_bin(a_hour, bin) == cur_hour);
  assign match = hit_s && hit_m && hit_h;
endmodule

// File: rtl/tod_update_engine.sv
`timescale 1ns/1ps
module tod_update_engine
  import tod_pkg::*;
#(
  parameter int YEAR_W     = 9,
  parameter int TICK_DELAY = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_pulse,
  input  logic       tick_32k,
  input  logic [2:0] osc_sel,
  input  logic       hold,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic       alarm_en,
  input  logic       upd_en,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [7:0] alarm_sec,
  input  logic [7:0] alarm_min,
  input  logic [7:0] alarm_hour,
  output logic [7:0] t_sec,
  output logic [7:0] t_min,
  output logic [7:0] t_hour,
  output logic [7:0] t_wday,
  output logic [7:0] t_mday,
  output logic [7:0] t_mon,
  output logic [7:0] t_year,
  output logic       uip,
  output logic       alarm_pulse,
  output logic       upd_pulse
);
  logic [NFIELD-1:0][7:0] tbyte, tbyte_n, enc, src_b, dec_b;
  logic [NFIELD-1:0]      ld_mask;
  tod_lo_t                ld_lo, cur_lo;
  logic [YEAR_W-1:0]      ld_year, cur_year, yr_mod;
  logic                   step, finish, match, hold_q, hold_fall;
  logic                   alarm_n, upd_n;

  assign hold_fall = hold_q && !hold;

  tod_seq #(.TICK_DELAY(TICK_DELAY)) u_seq (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .tick(tick_32k),
    .osc_sel(osc_sel), .hold(hold), .step(step), .finish(finish), .uip(uip)
  );

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    assign src_b[g] = hold_fall ? tbyte[g] : wr_data;
    assign dec_b[g] = decode_field(3'(g), src_b[g], bin_mode, h24_mode);
    if (g < NFIELD-1) begin : g_lo
      assign ld_lo[g] = dec_b[g];
    end else begin : g_yr
      assign ld_year = YEAR_W'(dec_b[g]);
    end
  end

  always_comb begin
    ld_mask = '0;
    if (hold_fall) ld_mask = '1;
    else if (wr_en && !hold && wr_sel != 3'd7) ld_mask = NFIELD'(1) << wr_sel;
  end

  tod_count #(.YEAR_W(YEAR_W)) u_count (
    .clk(clk), .rst_n(rst_n), .step(step), .ld_mask(ld_mask), .ld_lo(ld_lo),
    .ld_year(ld_year), .cur_lo(cur_lo), .cur_year(cur_year)
  );

  tod_alarm u_alarm (
    .cur_sec(cur_lo[FS_SEC]), .cur_min(cur_lo[FS_MIN]), .cur_hour(cur_lo[FS_HOUR]),
    .a_sec(alarm_sec), .a_min(alarm_min), .a_hour(alarm_hour),
    .bin(bin_mode), .match(match)
  );

  assign yr_mod = cur_year % YEAR_W'(100);

  always_comb begin
    enc[FS_SEC]  = bin_to_bcd(cur_lo[FS_SEC], bin_mode);
    enc[FS_MIN]  = bin_to_bcd(cur_lo[FS_MIN], bin_mode);
    enc[FS_HOUR] = encode_hour(cur_lo[FS_HOUR], bin_mode, h24_mode);
    enc[FS_WDAY] = bin_to_bcd(cur_lo[FS_WDAY], bin_mode);
    enc[FS_MDAY] = bin_to_bcd(cur_lo[FS_MDAY], bin_mode);
    enc[FS_MON]  = bin_to_bcd(cur_lo[FS_MON] + 8'd1, bin_mode);
    enc[FS_YEAR] = bin_to_bcd(8'(yr_mod), bin_mode);
  end

  always_comb begin
    for (int i = 0; i < NFIELD; i++) begin
      if (wr_en && wr_sel == 3'(i)) tbyte_n[i] = wr_data;
      else if (finish && !hold)     tbyte_n[i] = enc[i];
      else                          tbyte_n[i] = tbyte[i];
    end
    alarm_n = finish && alarm_en && match;
    upd_n   = finish && upd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbyte          <= '0;
      tbyte[FS_MDAY] <= 8'h01;
      tbyte[FS_MON]  <= 8'h01;
      hold_q         <= 1'b0;
      alarm_pulse    <= 1'b0;
      upd_pulse      <= 1'b0;
    end else begin
      tbyte       <= tbyte_n;
      hold_q      <= hold;
      alarm_pulse <= alarm_n;
      upd_pulse   <= upd_n;
    end
  end

  assign t_sec  = tbyte[FS_SEC];
  assign t_min  = tbyte[FS_MIN];
  assign t_hour = tbyte[FS_HOUR];
  assign t_wday = tbyte[FS_WDAY];
  assign t_mday = tbyte[FS_MDAY];
  assign t_mon  = tbyte[FS_MON];
  assign t_year = tbyte[FS_YEAR];

  assert_copy_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> $stable(tbyte));
  assert_alarm_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(alarm_en));
  assert_upd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> ($past(upd_en) && !uip));
endmodule

// File: tb/test_tod_update_engine.sv
`timescale 1ns/1ps
module test_tod_update_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, sec_pulse, tick_32k, hold, bin_mode, h24_mode, alarm_en, upd_en, wr_en;
  logic [2:0] osc_sel, wr_sel;
  logic [7:0] wr_data, alarm_sec, alarm_min, alarm_hour;
  logic [7:0] t_sec, t_min, t_hour, t_wday, t_mday, t_mon, t_year;
  logic       uip, alarm_pulse, upd_pulse;

  tod_update_engine i_tod_update_engine (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .tick_32k(tick_32k), .osc_sel(osc_sel),
    .hold(hold), .bin_mode(bin_mode), .h24_mode(h24_mode), .alarm_en(alarm_en),
    .upd_en(upd_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .alarm_sec(alarm_sec), .alarm_min(alarm_min), .alarm_hour(alarm_hour),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_wday(t_wday), .t_mday(t_mday),
    .t_mon(t_mon), .t_year(t_year), .uip(uip), .alarm_pulse(alarm_pulse), .upd_pulse(upd_pulse)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int ms, mm, mh, mw, md, mo, my;
  int eb[7];

  function automatic int tobcd(int v);
    return bin_mode ? (v & 255) : ((((v / 10) % 16) << 4) | (v % 10));
  endfunction
  function automatic int frbcd(int b);
    return bin_mode ? b : ((b >> 4) * 10 + (b & 15));
  endfunction
  function automatic int enc_hour(int h);
    return h24_mode ? tobcd(h) : (tobcd(h % 12) | ((h >= 12) ? 128 : 0));
  endfunction
  function automatic int mdays(int m0, int y);
    bit lp = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    case (m0)
      1: return lp ? 29 : 28;
      3, 5, 8, 10: return 30;
      default: return 31;
    endcase
  endfunction
  function automatic int enc_field(int i);
    case (i)
      0: return tobcd(ms);
      1: return tobcd(mm);
      2: return enc_hour(mh);
      3: return tobcd(mw);
      4: return tobcd(md);
      5: return tobcd(mo + 1);
      default: return tobcd(my % 100);
    endcase
  endfunction
  function automatic void load_field(int i, int b);
    case (i)
      0: ms = frbcd(b);
      1: mm = frbcd(b);
      2: mh = frbcd(b & 127) + ((!h24_mode && b >= 128) ? 12 : 0);
      3: mw = frbcd(b);
      4: md = frbcd(b);
      5: mo = frbcd(b) - 1;
      default: my = frbcd(b);
    endcase
  endfunction
  function automatic void m_step();
    ms++;
    if (ms >= 60) begin
      ms = 0; mm++;
      if (mm >= 60) begin
        mm = 0; mh++;
        if (mh >= 24) begin
          mh = 0; mw = (mw + 1 >= 7) ? 0 : mw + 1;
          md++;
          if (md > mdays(mo, my)) begin
            md = 1; mo++;
            if (mo >= 12) begin mo = 0; my++; end
          end
        end
      end
    end
  endfunction
  function automatic bit fmatch(int a, int v);
    return ((a & 192) == 192) || (frbcd(a) == v);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask
  task automatic chk_bytes(string tag);
    chk(tag, t_sec, eb[0]);  chk(tag, t_min, eb[1]);  chk(tag, t_hour, eb[2]);
    chk(tag, t_wday, eb[3]); chk(tag, t_mday, eb[4]); chk(tag, t_mon, eb[5]);
    chk(tag, t_year, eb[6]);
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
    eb[sel] = data & 255;
    if (!hold) load_field(sel, data & 255);
  endtask
  task automatic set_mode(bit b, bit h);
    @(negedge clk);
    bin_mode = b; h24_mode = h;
  endtask
  task automatic set_time(int s, int m, int h, int wd, int d, int mon1, int y);
    wr(0, tobcd(s)); wr(1, tobcd(m)); wr(2, enc_hour(h)); wr(3, tobcd(wd));
    wr(4, tobcd(d)); wr(5, tobcd(mon1)); wr(6, tobcd(y));
  endtask
  task automatic set_hold(bit v);
    bit was = hold;
    @(negedge clk);
    hold = v;
    @(negedge clk);
    if (was && !v) for (int i = 0; i < 7; i++) load_field(i, eb[i]);
  endtask

  // One accepted second: pulse, then eight ticks with random gaps.
  task automatic one_second(string tag, bit poke);
    bit ea;
    @(negedge clk); sec_pulse = 1'b1;
    @(negedge clk); sec_pulse = 1'b0;
    chk({tag, " R2 uip set"}, uip, hold ? 0 : 1);
    m_step();
    for (int k = 0; k < 8; k++) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      tick_32k = 1'b1;
      if (poke && k == 3) sec_pulse = 1'b1;
      @(negedge clk);
      tick_32k = 1'b0; sec_pulse = 1'b0;
      if (k == 6) begin
        chk({tag, " R2 pending sec"}, t_sec, eb[0]);
        chk({tag, " R2 pending uip"}, uip, hold ? 0 : 1);
      end
    end
    ea = alarm_en && fmatch(alarm_sec, ms) && fmatch(alarm_min, mm) && fmatch(alarm_hour, mh);
    if (!hold) for (int i = 0; i < 7; i++) eb[i] = enc_field(i);
    chk({tag, " R7 alarm"}, alarm_pulse, ea);
    chk({tag, " R8 upd"}, upd_pulse, upd_en);
    chk({tag, " R2 uip clear"}, uip, 0);
    chk_bytes(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; sec_pulse = 1'b0; tick_32k = 1'b0; osc_sel = 3'b010; hold = 1'b0;
    bin_mode = 1'b0; h24_mode = 1'b1; alarm_en = 1'b0; upd_en = 1'b0; wr_en = 1'b0;
    wr_sel = 3'd7; wr_data = 8'h00; alarm_sec = 8'h00; alarm_min = 8'h00; alarm_hour = 8'h00;
    ms = 0; mm = 0; mh = 0; mw = 0; md = 1; mo = 0; my = 0;
    eb = '{0, 0, 0, 0, 1, 1, 0};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk_bytes("R11 reset");
    chk("R11 uip", uip, 0);
    chk("R11 pulses", {alarm_pulse, upd_pulse}, 0);

    // R3 R6: year rollover in BCD 24h with update pulses
    upd_en = 1'b1;
    set_time(59, 59, 23, 6, 31, 12, 99);
    one_second("R3 R6 new year", 0);
    // R3 leap 2000
    set_time(59, 59, 23, 1, 28, 2, 0);
    one_second("R3 leap 2000", 0);
    // R3 2100 not leap: roll to year count 100, then rewrite without the year
    set_time(59, 59, 23, 0, 31, 12, 99);
    one_second("R6 year 100", 0);
    wr(5, tobcd(2)); wr(4, tobcd(28)); wr(2, enc_hour(23)); wr(1, tobcd(59)); wr(0, tobcd(59));
    one_second("R3 no leap 2100", 0);
    set_time(59, 59, 23, 2, 28, 2, 23);
    one_second("R3 no leap 2023", 0);
    set_time(59, 59, 23, 2, 30, 4, 24);
    one_second("R3 30-day month", 0);

    // R4 R5: binary, 12-hour
    set_mode(1, 0);
    set_time(59, 59, 11, 3, 10, 7, 45);
    one_second("R4 R5 noon", 0);
    chk("R5 noon byte", t_hour, 8'h80);
    set_time(59, 59, 23, 3, 10, 7, 45);
    one_second("R5 midnight", 0);
    chk("R5 midnight byte", t_hour, 8'h00);
    set_time(0, 0, 21, 3, 10, 7, 45);
    one_second("R5 pm byte", 0);
    chk("R4 R5 9pm binary", t_hour, 8'h89);

    // R1: divider stopped
    set_mode(0, 1);
    set_time(10, 20, 5, 1, 3, 3, 10);
    @(negedge clk); osc_sel = 3'b011; sec_pulse = 1'b1;
    @(negedge clk); sec_pulse = 1'b0;
    chk("R1 no uip", uip, 0);
    for (int k = 0; k < 12; k++) begin
      tick_32k = 1'b1; @(negedge clk); tick_32k = 1'b0; @(negedge clk);
      if (upd_pulse) chk("R1 no pulse", upd_pulse, 0);
    end
    chk_bytes("R1 frozen");
    osc_sel = 3'b010;

    // R7 alarm exact / wildcard / mismatch, with a pulse poked mid-window (R2)
    alarm_en = 1'b1;
    alarm_sec = 8'h11; alarm_min = 8'h20; alarm_hour = 8'h05;
    one_second("R7 exact", 1);
    one_second("R7 exact miss", 0);
    alarm_sec = 8'hC0; alarm_min = 8'h20; alarm_hour = 8'h06;
    one_second("R7 hour miss", 0);
    alarm_hour = 8'hC5;
    one_second("R7 all wild", 1);

    // R9 R10: hold freezes bytes, count still advances (seen by alarm)
    alarm_sec = 8'h15; alarm_min = 8'hFF; alarm_hour = 8'hC0;
    upd_en = 1'b0;
    set_hold(1);
    chk("R9 uip low", uip, 0);
    one_second("R9 hold alarm", 0);
    wr(0, tobcd(30));
    chk("R10 byte stored", t_sec, 8'h30);
    one_second("R9 R10 hold no load", 0);
    set_hold(0);
    upd_en = 1'b1;
    one_second("R10 reload", 0);
    chk("R10 reload sec", t_sec, 8'h31);

    // Random dates, modes and alarms
    for (int it = 0; it < 30; it++) begin
      int y, mon1, d, h, m, s;
      set_mode($urandom_range(0, 1), $urandom_range(0, 1));
      y = $urandom_range(0, 99); mon1 = $urandom_range(1, 12);
      d = ($urandom_range(0, 1) == 1) ? mdays(mon1 - 1, y) : $urandom_range(1, mdays(mon1 - 1, y));
      h = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
      m = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59);
      s = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59);
      set_time(s, m, h, $urandom_range(0, 6), d, mon1, y);
      alarm_sec  = 8'(($urandom_range(0, 1) == 1) ? 192 : tobcd((s + 1) % 60));
      alarm_min  = 8'(($urandom_range(0, 1) == 1) ? 192 : tobcd(m));
      alarm_hour = 8'(($urandom_range(0, 1) == 1) ? 192 : tobcd(h));
      alarm_en = 1'($urandom_range(0, 1)); upd_en = 1'($urandom_range(0, 1));
      for (int n = 0; n < int'($urandom_range(1, 2)); n++)
        one_second("R3 R4 R5 R7 random", $urandom_range(0, 1));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule